// File: doc/BRIEF.md
# Serial ADC Sweep Sequencer

This block runs a multi-channel serial analog-to-digital converter in sweep mode with no processor in the loop. A one-cycle start pulse captures four settings: a configuration word, a conversion command word, the number of samples wanted and a serial clock divider. The block then exchanges 16-bit words with the converter over a full-duplex synchronous serial link. Each frame opens with a one-period frame sync, and the data follows one bit later.

The first frame writes the configuration. The two low bits of that word select the converter's FIFO trigger depth, and the depth sets the length of every later burst. The block sends that many conversion commands and then waits for the converter's interrupt line. It then issues the same number of FIFO-read commands. Each returned word goes to one of two sample buffers in turn, through a one-cycle write port, and each buffer has its own address pointer. Conversion and drain bursts repeat until the requested number of samples is stored. The block then pulses done and goes idle.

Top module: `adc_sweep_ctrl`

## Requirements
- R1: After a synchronous reset, busy, done, buf_we, fs and sclk are low and cs_n is high.
- R2: A frame is one sclk period with fs high and sdo low, then 16 bits on sdo, most significant first. sdo changes on the falling sclk edge, and sdi is sampled on the rising edge of each of those 16 periods.
- R3: One sclk period lasts (1 + clk_div) system clock cycles. A clk_div of 0 is treated as 1.
- R4: The first frame after start carries cfg_word. The word received during that frame is never written to a buffer.
- R5: cfg_word[1:0] sets the burst length: 00 gives 7, 01 gives 5, 10 gives 3 and 11 gives 1. Each conversion burst is exactly that many frames carrying conv_word.
- R6: After a conversion burst, no frame starts until a rising edge arrives on adc_int. That edge starts a drain burst of burst-length frames, each carrying 16'hE000 (code 0xE in bits [15:12]).
- R7: The word received in each drain frame is written to a buffer. Writes alternate between buffers, starting with buffer 0 (buf_sel=0). Each buffer's address starts at 0 and rises by one per write to that buffer.
- R8: At least 6 idle system cycles separate the end of one frame from the start of the next.
- R9: cs_n is low and busy is high from the cycle after start until done. While idle, cs_n is high and no frame is sent.
- R10: Once the stored count equals sample_count, done pulses for one cycle, busy falls and the remaining drain frames of that burst are not sent.
- R11: A start pulse while busy is ignored, and the run continues with its original settings.
- R12: adc_int edges outside the wait-for-interrupt state are ignored. An interrupt held high starts only one drain burst.
- R13: A sample_count of 0 ends the run with done right after the configuration frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a sweep when idle |
| cfg_word | input | 16 | Configuration word sent first |
| conv_word | input | 16 | Conversion command word |
| sample_count | input | CNT_W | Number of samples to store |
| clk_div | input | DIV_W | Serial clock divider |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| fs | output | 1 | Frame sync |
| sdo | output | 1 | Serial data to the converter |
| sdi | input | 1 | Serial data from the converter |
| adc_int | input | 1 | Converter interrupt, asynchronous |
| buf_we | output | 1 | Sample buffer write strobe |
| buf_sel | output | 1 | Buffer select, 0 or 1 |
| buf_addr | output | ADDR_W | Write address within the selected buffer |
| buf_data | output | 16 | Sample word to write |

## Verification
On every cycle the assertions check several local timing rules. They check that the frame sync period carries no data and begins with sclk low, and that a frame starts only after the idle gap. They also check that frames appear only while chip select is low, that the done pulse and the interrupt pulse last one cycle, that buffer writes never fall on adjacent cycles, and that a start during a run leaves the latched count unchanged. The bench scenarios cover the end-to-end behaviour: decoding each burst depth, the command word in every frame, the measured sclk period, and the exact buffer, address and data of every write compared against a model converter. They also show that a stray interrupt pulse, a held interrupt, a start during a run and a zero count each have the effect the requirements give.

// File: rtl/adc_sweep_pkg.sv
package adc_sweep_pkg;

    localparam int WORD_W     = 16;
    localparam int FRAME_BITS = 16;
    localparam int PER_W      = 5;

    localparam logic [3:0]        OP_FIFO_READ   = 4'hE;
    localparam logic [WORD_W-1:0] FIFO_READ_WORD = {OP_FIFO_READ, 12'h000};

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CFG_SEND,
        SQ_CFG_WAIT,
        SQ_CONV_SEND,
        SQ_CONV_WAIT,
        SQ_IRQ_WAIT,
        SQ_RD_SEND,
        SQ_RD_WAIT
    } seq_state_t;

    // Burst depth selected by the two low configuration bits
    function automatic logic [2:0] burst_depth(input logic [1:0] code);
        logic [2:0] d;
        case (code)
            2'b00:   d = 3'd7;
            2'b01:   d = 3'd5;
            2'b10:   d = 3'd3;
            default: d = 3'd1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/adc_irq_sync.sv
module adc_irq_sync (
    input  logic clk,
    input  logic rst,
    input  logic irq_async,
    output logic irq_pulse
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 3'b000;
        end else begin
            sync_q <= {sync_q[1:0], irq_async};
        end
    end

    assign irq_pulse = sync_q[1] & ~sync_q[2];

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R12

endmodule

// File: rtl/adc_ser_port.sv
module adc_ser_port
    import adc_sweep_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  div,
    input  logic              tx_valid,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_accept,
    output logic              rx_valid,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              fs,
    output logic              sdo,
    input  logic              sdi
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    logic              active;
    logic [PER_W-1:0]  per;
    logic [DIV_W-1:0]  pcnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic              rx_valid_q;
    logic [DIV_W-1:0]  div_eff;
    logic [DIV_W:0]    half;
    logic              tx_ready;

    assign div_eff   = (div == '0) ? DIV_W'(1) : div;
    assign half      = ({1'b0, div_eff} + 1'b1) >> 1;
    assign tx_ready  = !active && (gap_cnt == '0);
    assign tx_accept = tx_valid && tx_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            per        <= '0;
            pcnt       <= '0;
            gap_cnt    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_valid_q <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            if (!active) begin
                if (gap_cnt != '0) begin
                    gap_cnt <= gap_cnt - 1'b1;
                end else if (tx_valid) begin
                    active <= 1'b1;
                    per    <= '0;
                    pcnt   <= '0;
                    tx_sh  <= tx_word;
                end
            end else begin
                if ((per != '0) && ({1'b0, pcnt} == half)) begin
                    rx_sh <= {rx_sh[WORD_W-2:0], sdi};
                end
                if (pcnt == div_eff) begin
                    pcnt <= '0;
                    if (per == PER_W'(FRAME_BITS)) begin
                        active     <= 1'b0;
                        rx_valid_q <= 1'b1;
                        gap_cnt    <= GAP_W'(GAP_CYC);
                    end else begin
                        per <= per + 1'b1;
                        if (per != '0) begin
                            tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
                        end
                    end
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

    assign sclk     = active && ({1'b0, pcnt} >= half);
    assign fs       = active && (per == '0);
    assign sdo      = active && (per != '0) && tx_sh[WORD_W-1];
    assign rx_valid = rx_valid_q;
    assign rx_word  = rx_sh;

    // Independent idle-run counter used to check the inter-frame gap
    logic [3:0] idle_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_run <= 4'hF;
        end else if (active) begin
            idle_run <= '0;
        end else if (idle_run != 4'hF) begin
            idle_run <= idle_run + 1'b1;
        end
    end

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (rst)
        tx_accept |-> (idle_run >= 4'd6)); // R8

    AST_FS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        fs |-> !sdo); // R2

    AST_FS_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(fs) |-> !sclk); // R2

endmodule

// File: rtl/adc_sweep_seq.sv
module adc_sweep_seq
    import adc_sweep_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 10,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] cfg_in,
    input  logic [WORD_W-1:0] conv_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [DIV_W-1:0]  div_in,
    input  logic              tx_accept,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              irq_pulse,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_word,
    output logic [DIV_W-1:0]  div_q,
    output logic              busy,
    output logic              cs_n,
    output logic              done,
    output logic              buf_we,
    output logic              buf_sel,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [WORD_W-1:0] buf_data
);
    typedef struct packed {
        logic              we;
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } buf_wr_t;

    seq_state_t        state;
    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] conv_q;
    logic [CNT_W-1:0]  goal_q;
    logic [CNT_W-1:0]  stored;
    logic [CNT_W-1:0]  stored_nx;
    logic [2:0]        depth;
    logic [2:0]        left;
    logic [ADDR_W-1:0] ptr [2];
    logic              sel_q;
    logic              done_q;
    buf_wr_t           wr_q;

    assign stored_nx = stored + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cfg_q   <= '0;
            conv_q  <= '0;
            goal_q  <= '0;
            div_q   <= '0;
            stored  <= '0;
            depth   <= 3'd1;
            left    <= '0;
            ptr[0]  <= '0;
            ptr[1]  <= '0;
            sel_q   <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= '0;
        end else begin
            done_q  <= 1'b0;
            wr_q.we <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        cfg_q  <= cfg_in;
                        conv_q <= conv_in;
                        goal_q <= count_in;
                        div_q  <= div_in;
                        depth  <= burst_depth(cfg_in[1:0]);
                        stored <= '0;
                        ptr[0] <= '0;
                        ptr[1] <= '0;
                        sel_q  <= 1'b0;
                        state  <= SQ_CFG_SEND;
                    end
                end
                SQ_CFG_SEND: begin
                    if (tx_accept) state <= SQ_CFG_WAIT;
                end
                SQ_CFG_WAIT: begin
                    if (rx_valid) begin
                        if (goal_q == '0) begin
                            done_q <= 1'b1;
                            state  <= SQ_IDLE;
                        end else begin
                            left  <= depth;
                            state <= SQ_CONV_SEND;
                        end
                    end
                end
                SQ_CONV_SEND: begin
                    if (tx_accept) state <= SQ_CONV_WAIT;
                end
                SQ_CONV_WAIT: begin
                    if (rx_valid) begin
                        if (left == 3'd1) begin
                            state <= SQ_IRQ_WAIT;
                        end else begin
                            left  <= left - 1'b1;
                            state <= SQ_CONV_SEND;
                        end
                    end
                end
                SQ_IRQ_WAIT: begin
                    if (irq_pulse) begin
                        left  <= depth;
                        state <= SQ_RD_SEND;
                    end
                end
                SQ_RD_SEND: begin
                    if (tx_accept) state <= SQ_RD_WAIT;
                end
                SQ_RD_WAIT: begin
                    if (rx_valid) begin
                        wr_q.we     <= 1'b1;
                        wr_q.sel    <= sel_q;
                        wr_q.addr   <= ptr[sel_q];
                        wr_q.data   <= rx_word;
                        ptr[sel_q]  <= ptr[sel_q] + 1'b1;
                        sel_q       <= ~sel_q;
                        stored      <= stored_nx;
                        if (stored_nx == goal_q) begin
                            done_q <= 1'b1;
                            state  <= SQ_IDLE;
                        end else if (left == 3'd1) begin
                            left  <= depth;
                            state <= SQ_CONV_SEND;
                        end else begin
                            left  <= left - 1'b1;
                            state <= SQ_RD_SEND;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_word  = '0;
        case (state)
            SQ_CFG_SEND: begin
                tx_valid = 1'b1;
                tx_word  = cfg_q;
            end
            SQ_CONV_SEND: begin
                tx_valid = 1'b1;
                tx_word  = conv_q;
            end
            SQ_RD_SEND: begin
                tx_valid = 1'b1;
                tx_word  = FIFO_READ_WORD;
            end
            default: begin
                tx_valid = 1'b0;
                tx_word  = '0;
            end
        endcase
    end

    assign busy     = (state != SQ_IDLE);
    assign cs_n     = (state == SQ_IDLE);
    assign done     = done_q;
    assign buf_we   = wr_q.we;
    assign buf_sel  = wr_q.sel;
    assign buf_addr = wr_q.addr;
    assign buf_data = wr_q.data;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(goal_q)); // R11

    AST_WE_SPACED: assert property (@(posedge clk) disable iff (rst)
        buf_we |=> !buf_we); // R7

endmodule

// File: rtl/adc_sweep_ctrl.sv
module adc_sweep_ctrl
    import adc_sweep_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int ADDR_W  = 10,
    parameter int DIV_W   = 8,
    parameter int GAP_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       cfg_word,
    input  logic [15:0]       conv_word,
    input  logic [CNT_W-1:0]  sample_count,
    input  logic [DIV_W-1:0]  clk_div,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              fs,
    output logic              sdo,
    input  logic              sdi,
    input  logic              adc_int,
    output logic              buf_we,
    output logic              buf_sel,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [15:0]       buf_data
);
    logic              tx_valid;
    logic [WORD_W-1:0] tx_word;
    logic              tx_accept;
    logic              rx_valid;
    logic [WORD_W-1:0] rx_word;
    logic              irq_pulse;
    logic [DIV_W-1:0]  div_q;

    adc_irq_sync u_irq (
        .clk       (clk),
        .rst       (rst),
        .irq_async (adc_int),
        .irq_pulse (irq_pulse)
    );

    adc_ser_port #(
        .DIV_W   (DIV_W),
        .GAP_CYC (GAP_CYC)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .div       (div_q),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .tx_accept (tx_accept),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .sclk      (sclk),
        .fs        (fs),
        .sdo       (sdo),
        .sdi       (sdi)
    );

    adc_sweep_seq #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DIV_W  (DIV_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg_word),
        .conv_in   (conv_word),
        .count_in  (sample_count),
        .div_in    (clk_div),
        .tx_accept (tx_accept),
        .rx_valid  (rx_valid),
        .rx_word   (rx_word),
        .irq_pulse (irq_pulse),
        .tx_valid  (tx_valid),
        .tx_word   (tx_word),
        .div_q     (div_q),
        .busy      (busy),
        .cs_n      (cs_n),
        .done      (done),
        .buf_we    (buf_we),
        .buf_sel   (buf_sel),
        .buf_addr  (buf_addr),
        .buf_data  (buf_data)
    );

    AST_FS_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        fs |-> !cs_n); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fs && !sclk)); // R9

endmodule

// File: tb/test_adc_sweep_ctrl.sv
module test_adc_sweep_ctrl;
    localparam int CNT_W   = 12;
    localparam int ADDR_W  = 10;
    localparam int DIV_W   = 8;
    localparam int GAP_CYC = 8;
    localparam int ITEM_W  = 1 + ADDR_W + 16;
    localparam int CLK_NS  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [15:0]       cfg_word = '0;
    logic [15:0]       conv_word = '0;
    logic [CNT_W-1:0]  sample_count = '0;
    logic [DIV_W-1:0]  clk_div = '0;
    logic              sdi = 1'b0;
    logic              adc_int = 1'b0;
    logic              busy, done, cs_n, sclk, fs, sdo;
    logic              buf_we, buf_sel;
    logic [ADDR_W-1:0] buf_addr;
    logic [15:0]       buf_data;

    always #5 clk = ~clk;

    adc_sweep_ctrl #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DIV_W(DIV_W), .GAP_CYC(GAP_CYC)
    ) i_adc_sweep_ctrl (
        .clk(clk), .rst(rst), .start(start), .cfg_word(cfg_word),
        .conv_word(conv_word), .sample_count(sample_count), .clk_div(clk_div),
        .busy(busy), .done(done), .cs_n(cs_n), .sclk(sclk), .fs(fs),
        .sdo(sdo), .sdi(sdi), .adc_int(adc_int), .buf_we(buf_we),
        .buf_sel(buf_sel), .buf_addr(buf_addr), .buf_data(buf_data)
    );

    int vectors = 0;
    int errors  = 0;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Converter model state
    logic [15:0]       exp_cfg = '0;
    logic [15:0]       exp_conv = '0;
    int                level = 1;
    int                div_e = 1;
    int                frame_in_run = 0;
    int                frame_id = 0;
    int                conv_in_burst = 0;
    int                reads_in_burst = 0;
    int                stores = 0;
    int                hold_cyc = 4;
    bit                wait_int = 0;
    bit                int_req = 0;
    bit                gen_busy = 0;
    bit                irq_mode = 0;
    bit                have_last = 0;
    time               t_last = 0;
    logic [ITEM_W-1:0] exp_q [$];

    // Driver side: converter model pushes expected buffer writes
    initial begin : adc_model
        forever begin : frame
            logic [15:0] resp;
            logic [15:0] cmd;
            time         t0;
            @(posedge fs);
            check(cs_n == 1'b0, "R9", cs_n, 0);
            check(!wait_int, irq_mode ? "R12" : "R6", wait_int, 0);
            if (have_last)
                check(($time - t_last) >= 7 * CLK_NS, "R8",
                      32'($time - t_last), 7 * CLK_NS);
            resp = {frame_id[7:0] ^ 8'h3C, ~frame_id[7:0]};
            frame_id++;
            cmd = '0;
            t0  = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge sclk);
                sdi = resp[15-i];
                @(posedge sclk);
                cmd[15-i] = sdo;
                if (i == 0) begin
                    t0 = $time;
                    check(fs == 1'b0, "R2", fs, 0);
                end
                if (i == 1)
                    check(($time - t0) == time'((div_e + 1) * CLK_NS), "R3",
                          32'($time - t0), (div_e + 1) * CLK_NS);
            end
            t_last    = $time;
            have_last = 1;
            if (frame_in_run == 0) begin
                check(cmd == exp_cfg, "R4", cmd, exp_cfg);
            end else if (cmd == 16'hE000) begin
                if (conv_in_burst != 0) begin
                    check(conv_in_burst == level, "R5", conv_in_burst, level);
                    conv_in_burst = 0;
                end
                reads_in_burst++;
                exp_q.push_back({stores[0], ADDR_W'(stores / 2), resp});
                stores++;
            end else begin
                check(cmd == exp_conv, "R2", cmd, exp_conv);
                if (reads_in_burst != 0) begin
                    check(reads_in_burst == level, "R6", reads_in_burst, level);
                    reads_in_burst = 0;
                end
                conv_in_burst++;
                check(conv_in_burst <= level, "R5", conv_in_burst, level);
                if (conv_in_burst == level) begin
                    wait_int = 1;
                    int_req  = 1;
                end
            end
            frame_in_run++;
        end
    end

    // Interrupt generator of the model converter
    initial begin : irq_gen
        forever begin
            wait (int_req == 1'b1);
            gen_busy = 1;
            int_req  = 0;
            repeat (30) @(negedge clk);
            wait_int = 0;
            adc_int  = 1'b1;
            repeat (hold_cyc) @(negedge clk);
            adc_int  = 1'b0;
            repeat (2) @(negedge clk);
            gen_busy = 0;
        end
    end

    // Monitor: pops and compares each buffer write
    always @(negedge clk) begin
        if (!rst && buf_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", {buf_sel, buf_addr, buf_data}, 0);
            end else begin
                logic [ITEM_W-1:0] e;
                e = exp_q.pop_front();
                check({buf_sel, buf_addr, buf_data} == e, "R7",
                      32'({buf_sel, buf_addr, buf_data}), 32'(e));
            end
        end
    end

    function automatic int depth_of(input logic [1:0] c);
        if (c == 2'b00) return 7;
        if (c == 2'b01) return 5;
        if (c == 2'b10) return 3;
        return 1;
    endfunction

    // mode: 0 plain, 1 stray interrupt, 2 start while busy, 3 held interrupt
    task automatic run_case(input logic [15:0] cfg, input logic [15:0] conv,
                            input int cnt, input int div, input int mode);
        bit got;
        exp_cfg        = cfg;
        exp_conv       = conv;
        level          = depth_of(cfg[1:0]);
        div_e          = (div == 0) ? 1 : div;
        frame_in_run   = 0;
        conv_in_burst  = 0;
        reads_in_burst = 0;
        stores         = 0;
        wait_int       = 0;
        irq_mode       = (mode == 1) || (mode == 3);
        hold_cyc       = (mode == 3) ? 400 : 4;
        @(negedge clk);
        cfg_word     = cfg;
        conv_word    = conv;
        sample_count = CNT_W'(cnt);
        clk_div      = DIV_W'(div);
        start        = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", busy, 1);
        check(cs_n == 1'b0, "R9", cs_n, 0);
        if (mode == 1) begin
            @(posedge fs);
            @(posedge fs);
            @(negedge clk);
            adc_int = 1'b1;
            repeat (4) @(negedge clk);
            adc_int = 1'b0;
        end
        if (mode == 2) begin
            @(posedge fs);
            @(negedge clk);
            cfg_word     = 16'hA003;
            conv_word    = 16'h6000;
            sample_count = CNT_W'(1);
            start        = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R11", busy, 1);
        end
        got = 0;
        for (int c = 0; c < 60000 && !got; c++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        check(got, "R10", got, 1);
        check(busy == 1'b0, "R10", busy, 0);
        check(cs_n == 1'b1, "R9", cs_n, 1);
        check(stores == cnt, (cnt == 0) ? "R13" : "R10", stores, cnt);
        if (cnt == 0) check(frame_in_run == 1, "R13", frame_in_run, 1);
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R10", done, 0);
        check(exp_q.size() == 0, "R7", exp_q.size(), 0);
        while (gen_busy) @(negedge clk);
        repeat (20) @(negedge clk);
        check(fs == 1'b0 && busy == 1'b0, "R9", {fs, busy}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0,   "R1", busy, 0);
        check(done == 1'b0,   "R1", done, 0);
        check(cs_n == 1'b1,   "R1", cs_n, 1);
        check(fs == 1'b0,     "R1", fs, 0);
        check(sclk == 1'b0,   "R1", sclk, 0);
        check(buf_we == 1'b0, "R1", buf_we, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        run_case(16'hA001, 16'h3000, 12, 3, 0); // depth 5, partial last burst
        run_case(16'hA000, 16'h7000, 7,  0, 1); // depth 7, divider 0, stray interrupt
        run_case(16'hA002, 16'h1000, 4,  2, 2); // depth 3, start while busy
        run_case(16'hA003, 16'h5000, 3,  4, 3); // depth 1, held interrupt
        run_case(16'hA001, 16'h2000, 0,  1, 0); // zero count

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule